// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

This block is a cycle-accurate, synthesizable model of a pipelined synchronous SRAM that accepts a new command on every enabled clock edge. It never needs an idle cycle between reads and writes. Each command carries its address, its read or write choice and its byte-lane write mask in the address cycle. The data for that command moves two enabled edges later. Write data is taken from `wdata` at that edge, and read data is registered onto `rdata` at that edge.

A load cycle takes in a fresh external address and command, and it also samples the three chip selects. An advance cycle does not take an address. It steps a 2-bit counter in the low address bits, and the burst keeps the command it was loaded with. The active-low clock enable freezes every register of the block when high, so a stall stretches the current cycle. The output enable only gates the read-data bus.

Top module: `zbt_sram`

## Requirements
- R1: While `rst_n` is low and after its release, `rvalid` is 0 and `rdata` is 0 (with `out_en_n` low).
- R2: A load cycle (`load_n` low, all chip selects asserted) captures `addr` and `wr_en` (1 = write, 0 = read). For a read, the word appears on `rdata` with `rvalid` high right after the second enabled rising edge that follows the address edge. For a write, `wdata` is taken at that same second enabled edge.
- R3: An advance cycle (`load_n` high) issues the address whose upper bits equal those of the previous slot and whose two low bits are the previous low bits plus 1 modulo 4. `wr_en` is ignored, and the burst keeps the loaded command.
- R4: `lane_we_n[i]` (active low) is sampled with each address slot, on a load or an advance. It enables writing of `wdata[8i+7:8i]` only. Lanes whose enable is high keep their stored contents.
- R5: The block is selected only when `sel0_n` is 0, `sel1_n` is 0 and `sel2` is 1 on a load cycle. A deselected load issues a no-op: nothing is written and `rvalid` is 0 for that slot. Advances after a deselected load remain no-ops. The selects are ignored on advance cycles.
- R6: When `clk_en_n` is high, the rising edge is ignored. `rdata`, `rvalid` and all pipeline and burst state hold, and every pending data phase is delayed by the stalled cycles.
- R7: When `out_en_n` is high, `rdata` is 0 at once. The internal state is not changed and `rvalid` is not affected.
- R8: Reads and writes may follow each other on consecutive edges with no idle cycle. A read issued right after a write to the same address returns the newly merged word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline and burst state |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the whole block |
| load_n | input | 1 | Low: load new address and command; high: advance burst |
| wr_en | input | 1 | Command on a load: 1 write, 0 read |
| addr | input | ADDR_W | Word address taken on a load |
| lane_we_n | input | LANES | Active-low byte-lane write enables, one per slot |
| sel0_n | input | 1 | Active-low chip select, sampled on loads |
| sel1_n | input | 1 | Active-low chip select, sampled on loads |
| sel2 | input | 1 | Active-high chip select, sampled on loads |
| out_en_n | input | 1 | Asynchronous active-low gate on `rdata` |
| wdata | input | LANES*LANE_W | Write data, taken two enabled edges after its address |
| rdata | output | LANES*LANE_W | Read data, zero while `out_en_n` is high |
| rvalid | output | 1 | High for one slot when `rdata` holds a selected read |

## Verification
The bench builds the block with `ADDR_W` = 5, which gives a 32-word array, and with four 8-bit lanes. With this size the whole array can be filled by bursts and then read back. Bursts starting at every low-bit offset reach the modulo-4 wrap, and writes and reads to the same word can be placed on neighbouring edges. The small depth also makes it cheap to prove that deselected or masked writes left earlier words intact. Stalls are placed inside bursts and between a command and its data phase, where a wrong freeze would shift data by a slot.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

  // Linear burst order: next low address bits, wrapping modulo 4.
  function automatic logic [1:0] burst_step(input logic [1:0] lo);
    return lo + 2'd1;
  endfunction

  // Device is selected only when every chip select is asserted.
  function automatic logic chip_selected(input logic a_n, input logic b_n, input logic c);
    return (!a_n) && (!b_n) && c;
  endfunction

endpackage

// File: rtl/zbt_cmd_ctrl.sv
module zbt_cmd_ctrl
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              sel0_n,
  input  logic              sel1_n,
  input  logic              sel2,
  output logic              iss_vld,
  output logic              iss_wr,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [LANES-1:0]  iss_be_n
);

  logic              act_q;
  logic              wr_q;
  logic [ADDR_W-3:0] hi_q;
  logic [1:0]        lo_q;

  always_comb begin
    if (!load_n) begin
      iss_vld  = chip_selected(sel0_n, sel1_n, sel2);
      iss_wr   = wr_en;
      iss_addr = addr;
    end else begin
      iss_vld  = act_q;
      iss_wr   = wr_q;
      iss_addr = {hi_q, burst_step(lo_q)};
    end
    iss_be_n = lane_we_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (en) begin
      act_q <= iss_vld;
      wr_q  <= iss_wr;
      hi_q  <= iss_addr[ADDR_W-1:2];
      lo_q  <= iss_addr[1:0];
    end
  end

endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] first_q,
  output logic [W-1:0] last_q
);

  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (en) begin
      st_q[0] <= d;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign first_q = st_q[0];
  assign last_q  = st_q[STAGES-1];

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    op_vld,
  input  logic                    op_wr,
  input  logic [ADDR_W-1:0]       op_addr,
  input  logic [LANES-1:0]        op_be_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rd_q,
  output logic                    rvalid_q
);

  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] bit_we;
  logic          do_wr;
  logic          do_rd;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [DW-1:0] mask);
    return (old_w & ~mask) | (new_w & mask);
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bit_we[g*LANE_W +: LANE_W] = {LANE_W{~op_be_n[g]}};
  end

  assign do_wr = en && op_vld && op_wr;
  assign do_rd = en && op_vld && !op_wr;

  always_ff @(posedge clk) begin
    if (do_wr) mem[op_addr] <= lane_merge(mem[op_addr], wdata, bit_we);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= '0;
      rvalid_q <= 1'b0;
    end else if (en) begin
      rvalid_q <= do_rd;
      if (do_rd) rd_q <= mem[op_addr];
    end
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    load_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    sel0_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);

  localparam int DW     = LANES * LANE_W;
  localparam int SLOT_W = 2 + LANES + ADDR_W;

  logic              en;
  logic              iss_vld;
  logic              iss_wr;
  logic [ADDR_W-1:0] iss_addr;
  logic [LANES-1:0]  iss_be_n;
  logic [SLOT_W-1:0] s1_slot;
  logic [SLOT_W-1:0] s2_slot;
  logic              s1_vld;
  logic              s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic              s2_vld;
  logic              s2_wr;
  logic [LANES-1:0]  s2_be_n;
  logic [ADDR_W-1:0] s2_addr;
  logic [DW-1:0]     rd_q;

  assign en = !clk_en_n;

  zbt_cmd_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .load_n(load_n), .wr_en(wr_en),
    .addr(addr), .lane_we_n(lane_we_n), .sel0_n(sel0_n), .sel1_n(sel1_n),
    .sel2(sel2), .iss_vld(iss_vld), .iss_wr(iss_wr), .iss_addr(iss_addr),
    .iss_be_n(iss_be_n)
  );

  zbt_pipe #(.W(SLOT_W), .STAGES(2)) u_pipe (
    .clk(clk), .rst_n(rst_n), .en(en),
    .d({iss_vld, iss_wr, iss_be_n, iss_addr}),
    .first_q(s1_slot), .last_q(s2_slot)
  );

  assign {s1_vld, s1_wr} = s1_slot[SLOT_W-1 -: 2];
  assign s1_addr         = s1_slot[ADDR_W-1:0];
  assign {s2_vld, s2_wr, s2_be_n, s2_addr} = s2_slot;

  zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .en(en), .op_vld(s2_vld), .op_wr(s2_wr),
    .op_addr(s2_addr), .op_be_n(s2_be_n), .wdata(wdata),
    .rd_q(rd_q), .rvalid_q(rvalid)
  );

  assign rdata = out_en_n ? '0 : rd_q;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              load_n,
  input logic              sel0_n,
  input logic              sel1_n,
  input logic              sel2,
  input logic              out_en_n,
  input logic [DW-1:0]     rdata,
  input logic              rvalid,
  input logic [DW-1:0]     rd_q,
  input logic              iss_vld,
  input logic              iss_wr,
  input logic [ADDR_W-1:0] iss_addr,
  input logic              s1_vld,
  input logic              s1_wr,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              s2_vld,
  input logic              s2_wr
);

  // R3: an advance follows the previous slot in linear order
  p_burst_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load_n && iss_vld) |->
      (s1_vld && iss_addr[ADDR_W-1:2] == s1_addr[ADDR_W-1:2] &&
       iss_addr[1:0] == 2'(s1_addr[1:0] + 2'd1)));

  // R3: an advance keeps the loaded command
  p_burst_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load_n && iss_vld) |-> (iss_wr == s1_wr));

  // R5: a deselected load issues a no-op
  p_deselect_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && (sel0_n || sel1_n || !sel2)) |-> !iss_vld);

  // R5: a write or no-op slot never raises rvalid
  p_write_no_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (!s2_vld || s2_wr)) |=> !rvalid);

  // R6: a stalled edge changes nothing
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(rd_q) && $stable(rvalid) && $stable(s1_addr) && $stable(s1_vld)));

  // R7: output enable high forces the bus to zero
  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (rdata == '0));

endmodule

bind zbt_sram zbt_sram_chk #(.ADDR_W(ADDR_W), .DW(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .load_n(load_n), .sel0_n(sel0_n),
  .sel1_n(sel1_n), .sel2(sel2), .out_en_n(out_en_n), .rdata(rdata),
  .rvalid(rvalid), .rd_q(rd_q), .iss_vld(iss_vld), .iss_wr(iss_wr),
  .iss_addr(iss_addr), .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr),
  .s2_vld(s2_vld), .s2_wr(s2_wr)
);

// File: tb/zbt_sram_tb_top.sv
module zbt_sram_tb_top;

  localparam int AW = 5;
  localparam int LANES = 4;
  localparam int LW = 8;
  localparam int DW = LANES * LW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          clk_en_n = 1'b1;
  logic          load_n = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    lane_we_n = 4'hF;
  logic          sel0_n = 1'b0, sel1_n = 1'b0, sel2 = 1'b1;
  logic          out_en_n = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  zbt_sram #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n),
    .wr_en(wr_en), .addr(addr), .lane_we_n(lane_we_n), .sel0_n(sel0_n),
    .sel1_n(sel1_n), .sel2(sel2), .out_en_n(out_en_n), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid)
  );

  typedef struct { bit vld; bit wr; logic [AW-1:0] a; logic [3:0] be; string tag; } slot_t;
  typedef struct { bit vld; logic [DW-1:0] data; string tag; } exp_t;

  slot_t         pend[$];
  exp_t          expq[$];
  logic [DW-1:0] ref_mem [1 << AW];
  bit            b_act = 0, b_wr = 0;
  logic [AW-1:0] b_addr = '0;
  logic [31:0]   wcnt = 0;
  string         cur_tag = "R2";
  logic [2:0]    sel_set = 3'b001;   // {sel0_n, sel1_n, sel2}
  bit            oe_set = 0;         // value driven on out_en_n
  int            n_checks = 0, n_fail = 0;
  bit            done = 0, mon_on = 0;

  task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] n, logic [3:0] be);
    logic [DW-1:0] r = o;
    for (int i = 0; i < LANES; i++) if (!be[i]) r[i*LW +: LW] = n[i*LW +: LW];
    return r;
  endfunction

  // Driver: one call per clock; stimulus is sampled at the following rising edge.
  task automatic cyc(bit en, bit ld, bit wr, logic [AW-1:0] a, logic [3:0] be);
    slot_t s, ns;
    exp_t  e;
    logic [DW-1:0] wd;
    @(posedge clk); #2;
    clk_en_n = !en; load_n = !ld; wr_en = wr; addr = a; lane_we_n = be;
    {sel0_n, sel1_n, sel2} = sel_set; out_en_n = oe_set;
    wd = 32'hDEAD_0000 ^ (wcnt * 32'h0001_1357);
    wcnt = wcnt + 1;
    wdata = ~wd;
    if (en) begin
      e.vld = 0; e.data = '0; e.tag = cur_tag;
      if (pend.size() == 2) begin
        s = pend.pop_front();
        e.tag = s.tag;
        if (s.vld && s.wr) begin
          wdata = wd;
          ref_mem[s.a] = merge(ref_mem[s.a], wd, s.be);
        end else if (s.vld) begin
          e.vld = 1; e.data = ref_mem[s.a];
        end
      end
      expq.push_back(e);
      if (ld) begin
        b_act = !sel_set[2] && !sel_set[1] && sel_set[0];
        b_wr = wr; b_addr = a;
      end else begin
        b_addr = {b_addr[AW-1:2], 2'(b_addr[1:0] + 2'd1)};
      end
      ns.vld = b_act; ns.wr = b_wr; ns.a = b_addr; ns.be = be; ns.tag = cur_tag;
      pend.push_back(ns);
    end
  endtask

  // Monitor
  bit            en_edge = 0, last_ok = 0, last_rv = 0;
  logic [DW-1:0] last_rd = '0;
  always @(posedge clk) en_edge = !clk_en_n;

  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (en_edge) begin
          if (expq.size() == 0) chk(0, "R2", "unexpected edge, empty queue", '0, '0);
          else begin
            e = expq.pop_front();
            chk(rvalid == e.vld, e.tag, "rvalid", DW'(rvalid), DW'(e.vld));
            if (e.vld) begin
              if (!out_en_n) chk(rdata == e.data, e.tag, "rdata", rdata, e.data);
              else chk(rdata == '0, "R7", "rdata gated", rdata, '0);
            end
          end
        end else begin
          if (!out_en_n && last_ok) begin
            chk(rvalid == last_rv, "R6", "rvalid held in stall", DW'(rvalid), DW'(last_rv));
            chk(rdata == last_rd, "R6", "rdata held in stall", rdata, last_rd);
          end else if (out_en_n) chk(rdata == '0, "R7", "rdata gated in stall", rdata, '0);
        end
        if (!out_en_n) begin last_ok = 1; last_rv = rvalid; last_rd = rdata; end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rvalid == 0, "R1", "rvalid in reset", DW'(rvalid), '0);
    chk(rdata == '0, "R1", "rdata in reset", rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rvalid == 0, "R1", "rvalid after reset", DW'(rvalid), '0);
    chk(rdata == '0, "R1", "rdata after reset", rdata, '0);
    mon_on = 1;

    // R2: fill the array with aligned write bursts
    cur_tag = "R2";
    for (int b = 0; b < 8; b++) begin
      cyc(1, 1, 1, AW'(b * 4), 4'h0);
      for (int k = 0; k < 3; k++) cyc(1, 0, 0, '0, 4'h0);
    end
    cyc(1, 1, 0, 5'd0, 4'h0);
    for (int k = 0; k < 3; k++) cyc(1, 0, 1, '0, 4'h0);

    // R3: wrap from offset 1 and 2, wr_en toggled on advances is ignored
    cur_tag = "R3";
    cyc(1, 1, 0, 5'd5, 4'h0);
    cyc(1, 0, 1, '0, 4'h0); cyc(1, 0, 1, '0, 4'h0); cyc(1, 0, 0, '0, 4'h0);
    cyc(1, 1, 1, 5'd10, 4'h0);
    cyc(1, 0, 0, '0, 4'h0); cyc(1, 0, 0, '0, 4'h0); cyc(1, 0, 1, '0, 4'h0);
    cyc(1, 1, 0, 5'd11, 4'h0);
    for (int k = 0; k < 3; k++) cyc(1, 0, 1, '0, 4'h0);

    // R4: lane masks on loads and per beat of a burst
    cur_tag = "R4";
    cyc(1, 1, 1, 5'd3, 4'b1010);
    cyc(1, 1, 1, 5'd17, 4'b0111);
    cyc(1, 1, 1, 5'd20, 4'b1110);
    cyc(1, 0, 0, '0, 4'b1101); cyc(1, 0, 0, '0, 4'b1011); cyc(1, 0, 0, '0, 4'hF);
    cyc(1, 1, 0, 5'd3, 4'h0); cyc(1, 1, 0, 5'd17, 4'h0);
    cyc(1, 1, 0, 5'd20, 4'h0);
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, '0, 4'h0);

    // R8: back-to-back mixed traffic to the same words
    cur_tag = "R8";
    cyc(1, 1, 1, 5'd12, 4'h0); cyc(1, 1, 0, 5'd12, 4'h0);
    cyc(1, 1, 1, 5'd13, 4'b1100); cyc(1, 1, 0, 5'd13, 4'h0);
    cyc(1, 1, 0, 5'd12, 4'h0); cyc(1, 1, 1, 5'd12, 4'b0011);
    cyc(1, 1, 0, 5'd12, 4'h0);

    // R5: deselected loads with each select, and selects ignored on advances
    cur_tag = "R5";
    sel_set = 3'b101; cyc(1, 1, 1, 5'd1, 4'h0); cyc(1, 0, 0, '0, 4'h0);
    sel_set = 3'b011; cyc(1, 1, 1, 5'd2, 4'h0);
    sel_set = 3'b000; cyc(1, 1, 0, 5'd6, 4'h0); cyc(1, 0, 0, '0, 4'h0);
    sel_set = 3'b001; cyc(1, 1, 1, 5'd24, 4'h0);
    sel_set = 3'b110; cyc(1, 0, 0, '0, 4'h0);
    sel_set = 3'b000; cyc(1, 0, 0, '0, 4'h0); cyc(1, 0, 0, '0, 4'h0);
    sel_set = 3'b001;
    cyc(1, 1, 0, 5'd1, 4'h0); cyc(1, 1, 0, 5'd2, 4'h0); cyc(1, 1, 0, 5'd6, 4'h0);
    cyc(1, 1, 0, 5'd24, 4'h0);
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, '0, 4'h0);

    // R6: stalls inside bursts and between command and data phase
    cur_tag = "R6";
    cyc(1, 1, 1, 5'd28, 4'h0); cyc(0, 1, 0, 5'd9, 4'h0);
    cyc(1, 0, 0, '0, 4'h0); cyc(0, 0, 0, '0, 4'h0); cyc(0, 1, 1, 5'd3, 4'h0);
    cyc(1, 0, 0, '0, 4'b0101); cyc(1, 0, 0, '0, 4'h0);
    cyc(1, 1, 0, 5'd30, 4'h0); cyc(0, 0, 1, '0, 4'h0);
    for (int k = 0; k < 3; k++) begin cyc(1, 0, 0, '0, 4'h0); cyc(0, 1, 1, 5'd0, 4'h0); end

    // R7: output gate during reads and stalls
    cur_tag = "R7";
    oe_set = 1;
    cyc(1, 1, 0, 5'd8, 4'h0); cyc(1, 0, 0, '0, 4'h0); cyc(1, 0, 0, '0, 4'h0);
    cyc(0, 0, 0, '0, 4'h0); cyc(1, 0, 0, '0, 4'h0);
    oe_set = 0;
    cyc(1, 1, 0, 5'd8, 4'h0); cyc(1, 0, 0, '0, 4'h0);

    // flush with deselected loads
    sel_set = 3'b100;
    for (int k = 0; k < 3; k++) cyc(1, 1, 0, '0, 4'h0);
    cyc(0, 1, 0, '0, 4'h0);
    repeat (3) @(posedge clk);
    chk(expq.size() == 0, "R2", "all expected slots seen", DW'(expq.size()), '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule